// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Ripple Blanking

This block turns one binary-coded decimal digit into the seven segment drives of a common-cathode display position. Segment outputs are active-high, so a 1 lights a segment. Three controls shape the result. A lamp-test input lights every segment. A blanking input darkens every segment. A ripple-blank input darkens the position only when the digit is zero.

The ripple-blank output rises when this position has been darkened because it held a suppressed zero. It feeds the ripple-blank input of the next less significant position. In a row of decoders, the most significant position has its ripple-blank input held high and the least significant has it held low. The leading zeros of a number then go dark, zeros between nonzero digits stay visible, and a value of zero still shows one 0.

The decoder is purely combinational and has no clock and no state. Several copies sit side by side in a multi-digit readout.

Top module: `bcd_rb_decoder`

## Requirements
- R1: The digit input is 4 bits wide, with bit 3 the most significant weight (8) and bit 0 the least (1). The segment bus is 7 bits wide, with seg[0]=a, seg[1]=b, seg[2]=c, seg[3]=d, seg[4]=e, seg[5]=f, seg[6]=g, and a 1 lights a segment.
- R2: With all three controls low, digits 0 to 9 light these segment sets: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg.
- R3: When lamp_test is 1, all seven segments are lit and rb_out is 0, whatever the digit, blank and rb_in are.
- R4: When blank is 1 and lamp_test is 0, all segments are dark and rb_out is 0, whatever the digit and rb_in are.
- R5: When the digit is 0, rb_in is 1, and both lamp_test and blank are 0, all segments are dark and rb_out is 1.
- R6: When lamp_test and blank are 0 and either the digit is 1 to 9 or rb_in is 0, the segments show the R2 pattern and rb_out is 0.
- R7: Codes 10 to 15 with lamp_test 0 give all segments dark and rb_out 0, whatever rb_in is.
- R8: Four decoders are chained from most to least significant. The top position has rb_in=1, each rb_out drives the rb_in of the next lower position except the last, and the last position has rb_in=0. In this chain, leading zeros are dark, inner zeros show 0, and the value 0000 shows a single 0 in the last position.
- R9: The outputs depend only on the present inputs and are valid in the same cycle that the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit | input | 4 | BCD digit, bit 3 most significant |
| lamp_test | input | 1 | Light all segments (highest priority) |
| blank | input | 1 | Darken all segments (second priority) |
| rb_in | input | 1 | Suppress this position if its digit is zero |
| seg | output | 7 | Segment drives, seg[0]=a through seg[6]=g, active-high |
| rb_out | output | 1 | High when this position was suppressed as a zero |

## Verification
The decoder holds no register, so every segment pattern and every rb_out value is due in the same clock period in which the inputs change, and chained results are due in that same period after the ripple path settles. The bench changes inputs one time unit after a rising edge of its pacing clock. It reads results at the following falling edge, which gives the combinational path half a period to settle. No check waits for, or depends on, any later edge.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int DIGIT_W  = 4;
  localparam int SEG_N    = 7;
  localparam int DEC_MAX  = 9;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_N-1:0]   seg_t;

  // How the output stage drives the segment bus.
  typedef enum logic [1:0] {
    DRV_GLYPH = 2'd0,
    DRV_ALL   = 2'd1,
    DRV_DARK  = 2'd2
  } drive_e;

  localparam seg_t SEG_ALL_ON  = {SEG_N{1'b1}};
  localparam seg_t SEG_ALL_OFF = {SEG_N{1'b0}};

  // Bit order g f e d c b a, i.e. bit k drives segment 'a'+k.
  function automatic seg_t glyph_of(input digit_t d);
    seg_t p;
    unique case (d)
      4'd0:    p = 7'b0111111;
      4'd1:    p = 7'b0000110;
      4'd2:    p = 7'b1011011;
      4'd3:    p = 7'b1001111;
      4'd4:    p = 7'b1100110;
      4'd5:    p = 7'b1101101;
      4'd6:    p = 7'b1111101;
      4'd7:    p = 7'b0000111;
      4'd8:    p = 7'b1111111;
      4'd9:    p = 7'b1101111;
      default: p = SEG_ALL_OFF;
    endcase
    return p;
  endfunction

  function automatic logic is_decimal(input digit_t d);
    return (d <= digit_t'(DEC_MAX));
  endfunction

endpackage

// File: rtl/seg_glyph_map.sv
module seg_glyph_map
  import seg_pkg::*;
(
  input  digit_t digit,
  output seg_t   glyph,
  output logic   glyph_valid,
  output logic   digit_zero
);

  always_comb begin
    glyph       = glyph_of(digit);
    glyph_valid = is_decimal(digit);
    digit_zero  = (digit == '0);
  end

endmodule

// File: rtl/seg_priority_ctrl.sv
module seg_priority_ctrl
  import seg_pkg::*;
(
  input  logic   lamp_test,
  input  logic   blank,
  input  logic   rb_in,
  input  logic   digit_zero,
  input  logic   glyph_valid,
  output drive_e mode,
  output logic   zero_suppressed,
  output logic   rb_out
);

  always_comb begin
    zero_suppressed = 1'b0;
    if (lamp_test) begin
      mode = DRV_ALL;
    end else if (blank) begin
      mode = DRV_DARK;
    end else if (rb_in && digit_zero) begin
      mode            = DRV_DARK;
      zero_suppressed = 1'b1;
    end else if (!glyph_valid) begin
      mode = DRV_DARK;
    end else begin
      mode = DRV_GLYPH;
    end
  end

  assign rb_out = zero_suppressed;

endmodule

// File: rtl/seg_output_stage.sv
module seg_output_stage
  import seg_pkg::*;
(
  input  drive_e mode,
  input  seg_t   glyph,
  output seg_t   seg
);

  for (genvar k = 0; k < SEG_N; k++) begin : g_seg
    always_comb begin
      unique case (mode)
        DRV_ALL:   seg[k] = 1'b1;
        DRV_GLYPH: seg[k] = glyph[k];
        default:   seg[k] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/bcd_rb_decoder.sv
module bcd_rb_decoder
  import seg_pkg::*;
(
  input  logic [3:0] digit,
  input  logic       lamp_test,
  input  logic       blank,
  input  logic       rb_in,
  output logic [6:0] seg,
  output logic       rb_out
);

  seg_t   glyph;
  logic   glyph_valid;
  logic   digit_zero;
  logic   zero_suppressed;
  drive_e mode;

  seg_glyph_map u_map (
    .digit       (digit),
    .glyph       (glyph),
    .glyph_valid (glyph_valid),
    .digit_zero  (digit_zero)
  );

  seg_priority_ctrl u_ctrl (
    .lamp_test       (lamp_test),
    .blank           (blank),
    .rb_in           (rb_in),
    .digit_zero      (digit_zero),
    .glyph_valid     (glyph_valid),
    .mode            (mode),
    .zero_suppressed (zero_suppressed),
    .rb_out          (rb_out)
  );

  seg_output_stage u_out (
    .mode  (mode),
    .glyph (glyph),
    .seg   (seg)
  );

endmodule

// File: rtl/bcd_rb_decoder_chk.sv
module bcd_rb_decoder_chk (
  input logic [3:0] digit,
  input logic       lamp_test,
  input logic       blank,
  input logic       rb_in,
  input logic [6:0] seg,
  input logic       rb_out
);

  logic known;
  assign known = !$isunknown({digit, lamp_test, blank, rb_in, seg, rb_out});

  always_comb begin
    if (known) begin
      if (lamp_test)
        assert_lamp_all_on_R3: assert (seg == 7'h7F && !rb_out);
      if (!lamp_test && blank)
        assert_blank_dark_R4: assert (seg == 7'h00 && !rb_out);
      if (rb_out)
        assert_rbo_cause_R5: assert (seg == 7'h00 && digit == 4'd0 && rb_in && !blank);
      if (!lamp_test && !blank && digit != 4'd0)
        assert_nonzero_no_rbo_R6: assert (!rb_out);
      if (!lamp_test && digit > 4'd9)
        assert_invalid_dark_R7: assert (seg == 7'h00);
      if (!lamp_test && !blank && digit <= 4'd9 && !(digit == 4'd0 && rb_in))
        assert_glyph_lit_R2: assert (seg != 7'h00);
    end
  end

endmodule

bind bcd_rb_decoder bcd_rb_decoder_chk u_chk (
  .digit     (digit),
  .lamp_test (lamp_test),
  .blank     (blank),
  .rb_in     (rb_in),
  .seg       (seg),
  .rb_out    (rb_out)
);

// File: tb/bcd_rb_decoder_tb.sv
`timescale 1ns/1ps
module bcd_rb_decoder_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // unit under test
  logic [3:0] digit;
  logic       lt, bi, rbi;
  logic [6:0] seg;
  logic       rbo;

  bcd_rb_decoder u_dut (
    .digit(digit), .lamp_test(lt), .blank(bi), .rb_in(rbi),
    .seg(seg), .rb_out(rbo)
  );

  // four-position chain, index 3 most significant
  logic [3:0] cd [4];
  logic [6:0] cs [4];
  logic       cr [4];

  bcd_rb_decoder u_pos3 (.digit(cd[3]), .lamp_test(1'b0), .blank(1'b0),
    .rb_in(1'b1),  .seg(cs[3]), .rb_out(cr[3]));
  bcd_rb_decoder u_pos2 (.digit(cd[2]), .lamp_test(1'b0), .blank(1'b0),
    .rb_in(cr[3]), .seg(cs[2]), .rb_out(cr[2]));
  bcd_rb_decoder u_pos1 (.digit(cd[1]), .lamp_test(1'b0), .blank(1'b0),
    .rb_in(cr[2]), .seg(cs[1]), .rb_out(cr[1]));
  bcd_rb_decoder u_pos0 (.digit(cd[0]), .lamp_test(1'b0), .blank(1'b0),
    .rb_in(1'b0),  .seg(cs[0]), .rb_out(cr[0]));

  // Per segment: bit n set when decimal digit n lights it.
  function automatic logic [9:0] lit_set(input int s);
    case (s)
      0: return 10'b1111101101; // a
      1: return 10'b1110011111; // b
      2: return 10'b1111111011; // c
      3: return 10'b1101101101; // d
      4: return 10'b0101000101; // e
      5: return 10'b1101110001; // f
      default: return 10'b1101111100; // g
    endcase
  endfunction

  function automatic logic [6:0] shape(input int d);
    logic [6:0] r = '0;
    if (d <= 9) for (int s = 0; s < 7; s++) r[s] = lit_set(s)[d];
    return r;
  endfunction

  function automatic logic [6:0] exp_seg(input int d, input bit l, input bit b, input bit r);
    if (l) return 7'h7F;
    if (b) return 7'h00;
    if (d == 0 && r) return 7'h00;
    return shape(d);
  endfunction

  function automatic bit exp_rbo(input int d, input bit l, input bit b, input bit r);
    return !l && !b && r && d == 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_for(input int d, input bit l, input bit b, input bit r);
    if (l) return "R3";
    if (b) return "R4";
    if (d > 9) return "R7";
    if (d == 0 && r) return "R5";
    return "R6";
  endfunction

  task automatic unit(input int d, input bit l, input bit b, input bit r);
    @(posedge clk); #1;
    digit = 4'(d); lt = l; bi = b; rbi = r;
    @(negedge clk);
    chk({tag_for(d, l, b, r), " seg R9"}, seg, exp_seg(d, l, b, r));
    chk({tag_for(d, l, b, r), " rbo R9"}, rbo, exp_rbo(d, l, b, r));
  endtask

  task automatic chain(input int v);
    int dd [4];
    bit dark;
    dd[0] = v % 10; dd[1] = (v / 10) % 10; dd[2] = (v / 100) % 10; dd[3] = (v / 1000) % 10;
    @(posedge clk); #1;
    for (int i = 0; i < 4; i++) cd[i] = 4'(dd[i]);
    @(negedge clk);
    dark = 1'b1;
    for (int i = 3; i >= 0; i--) begin
      if (i == 0 || dd[i] != 0) dark = 1'b0;
      chk($sformatf("R8 value %0d pos %0d", v, i), cs[i], dark ? 0 : shape(dd[i]));
    end
  endtask

  initial begin
    void'($urandom(32'h5EC7_0D1E));
    digit = '0; lt = 0; bi = 0; rbi = 0;
    for (int i = 0; i < 4; i++) cd[i] = '0;
    // R1: bit positions checked directly (digit 1 = b,c only; 4'b1000 = 8 all lit)
    @(posedge clk); #1; digit = 4'b0001;
    @(negedge clk); chk("R1 seg order", seg, 7'b0000110);
    @(posedge clk); #1; digit = 4'b1000;
    @(negedge clk); chk("R1 msb weight", seg, 7'b1111111);
    // R2: every decimal glyph, no controls
    for (int d = 0; d < 10; d++) unit(d, 0, 0, 0);
    // all codes with each control pattern
    for (int d = 0; d < 16; d++)
      for (int m = 0; m < 8; m++) unit(d, m[2], m[1], m[0]);
    // random mix
    for (int n = 0; n < 400; n++)
      unit(int'($urandom_range(15)), ($urandom_range(7) == 0), ($urandom_range(5) == 0), $urandom_range(1) == 1);
    // R8 chain directed corners
    chain(0); chain(7); chain(10); chain(100); chain(1005); chain(9999); chain(1000); chain(203);
    for (int n = 0; n < 300; n++) chain(int'($urandom_range(9999)));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule